// File: doc/BRIEF.md
# Whole-Array Erase Sequencer

This block runs a whole-array erase over a small array that is split into blocks. A command decoder hands it one write at a time. A setup write (30h) followed directly by a confirm write (D0h) starts the run. The sequencer decides once which blocks may be erased, then visits them in rising block order. For each block it raises an erase request towards the array port and waits for the acknowledge, which also carries a pass/fail flag.

The run stops at once when a block fails. Blocks that are locked are skipped. Boot blocks are also skipped while write-protect is held low. If no block can be erased, or the supply is not good, the sequencer reports the reason in its status byte and never touches the array.

A suspend request has no effect on a running erase. Error bits stay set until reset. The ready/busy output and status bit 7 show when a run is active. A one-cycle start pulse and a one-cycle done pulse mark the two ends of each run.

Top module: `array_wipe_seq`

## Requirements
- R1: A write of 30h followed by a write of D0h as the next command write starts a run. In the cycle after the confirm edge, `start_pulse` is 1 for one cycle and `ready_busy_n` is 0, provided at least one block is eligible and `supply_ok` is 1.
- R2: After a 30h write, any other value as the next command write sets status bits 4 and 5. It starts no run and leaves the block ready. A D0h write with no 30h before it does nothing.
- R3: Eligible blocks are requested one at a time on `er_blk`, in strictly rising index order. Each eligible block is requested exactly once.
- R4: A block whose lock bit is 1 is never requested. A block whose bit in `BOOT_MASK` is 1 is requested only when `wp_n` is 1 at the confirm write.
- R5: An acknowledge with `er_fail`=1 ends the run at that block and sets status bit 5. No later block is requested.
- R6: If no block is eligible at the confirm write, status bits 1 and 5 are set and no request is made.
- R7: If `supply_ok` is 0 at the confirm write, status bits 3 and 5 are set and no request is made.
- R8: `ready_busy_n` and status bit 7 are 0 from the cycle after the confirm edge until the edge that finishes the run. `done` is 1 for exactly the cycle after that edge.
- R9: `suspend_req` has no effect. A pending request stays up on the same block whatever its value.
- R10: Lock bits and `wp_n` are sampled only at the confirm write. Changes made during a run do not alter which blocks are erased.
- R11: Command writes that arrive while a run is active are ignored. They also do not arm a later confirm.
- R12: The status byte has this layout: bit 7 = ready, bit 5 = erase error, bit 4 = command sequence error, bit 3 = supply error, bit 1 = lock error, and all other bits 0. Reset gives 80h. The error bits stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One command write this cycle |
| cmd_data | input | 8 | Command write value |
| supply_ok | input | 1 | Programming supply good |
| wp_n | input | 1 | Write protect, high = boot blocks erasable |
| lock_bits | input | N_BLK | Per-block lock bit, 1 = locked |
| suspend_req | input | 1 | Suspend request (no effect on this operation) |
| er_req | output | 1 | Per-block erase request |
| er_blk | output | BW | Index of the block being erased |
| er_ack | input | 1 | Erase acknowledge from the array port |
| er_fail | input | 1 | Failure flag, valid with er_ack |
| ready_busy_n | output | 1 | High when ready, low while a run is active |
| start_pulse | output | 1 | One-cycle pulse when a run begins |
| done | output | 1 | One-cycle pulse when a run ends |
| status | output | 8 | Status byte |

## Verification
Two events can land in the same cycle. The first is an acknowledge, which either advances the walk or stops it, arriving together with a suspend request. The bench toggles `suspend_req` on a fixed pattern for the whole test, so it meets acknowledges with and without failure. Each run is judged on the full list of requested blocks and on the final status byte. The second is a lock-bit change arriving together with, or just after, the confirm write. The bench inverts the lock bits in the cycle after the confirm and expects the erase order computed from the values seen at the confirm.

// File: rtl/wipe_pkg.sv
package wipe_pkg;
  localparam logic [7:0] CMD_SETUP   = 8'h30;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam int SB_READY  = 7;
  localparam int SB_ERASE  = 5;
  localparam int SB_SEQ    = 4;
  localparam int SB_SUPPLY = 3;
  localparam int SB_LOCK   = 1;
endpackage

// File: rtl/wipe_cmd_gate.sv
module wipe_cmd_gate
  import wipe_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_data,
  input  logic       busy,
  output logic       go,
  output logic       seq_err
);
  logic armed;
  logic take;

  assign take    = cmd_valid && !busy;
  assign go      = take && armed && (cmd_data == CMD_CONFIRM);
  assign seq_err = take && armed && (cmd_data != CMD_CONFIRM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      armed <= 1'b0;
    else if (busy)   armed <= 1'b0;
    else if (take)   armed <= !armed && (cmd_data == CMD_SETUP);
  end

  // Any accepted second write consumes the setup
  assert_disarm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && take) |=> !armed);
  // Writes during a run never arm the gate
  assert_busy_ignores_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !armed);
endmodule

// File: rtl/wipe_eligibility.sv
module wipe_eligibility #(
  parameter int               N_BLK     = 8,
  parameter logic [N_BLK-1:0] BOOT_MASK = '0
) (
  input  logic [N_BLK-1:0] lock_bits,
  input  logic             wp_n,
  output logic [N_BLK-1:0] elig
);
  for (genvar i = 0; i < N_BLK; i++) begin : g_blk
    if (BOOT_MASK[i]) begin : g_boot
      assign elig[i] = !lock_bits[i] && wp_n;
    end else begin : g_plain
      assign elig[i] = !lock_bits[i];
    end
  end
endmodule

// File: rtl/wipe_walker.sv
module wipe_walker #(
  parameter int N_BLK = 8,
  localparam int BW = (N_BLK > 1) ? $clog2(N_BLK) : 1,
  localparam int IW = $clog2(N_BLK + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [N_BLK-1:0] mask_in,
  input  logic             er_ack,
  input  logic             er_fail,
  input  logic             suspend_req,
  output logic             running,
  output logic             er_req,
  output logic [BW-1:0]    er_blk,
  output logic             start_pulse,
  output logic             done,
  output logic             fail_hit
);
  logic [N_BLK-1:0] mask_q;
  logic [IW-1:0]    idx;
  logic [IW-1:0]    nxt;
  logic             pass_hit;

  // Lowest set bit of m at or above 'from'; N_BLK when none is left
  function automatic logic [IW-1:0] next_blk(input logic [N_BLK-1:0] m,
                                             input logic [IW-1:0]    from);
    next_blk = IW'(N_BLK);
    for (int i = N_BLK - 1; i >= 0; i--)
      if (m[i] && (IW'(i) >= from)) next_blk = IW'(i);
  endfunction

  assign er_req   = running;
  assign er_blk   = idx[BW-1:0];
  assign fail_hit = running && er_ack && er_fail;
  assign pass_hit = running && er_ack && !er_fail;
  assign nxt      = next_blk(mask_q, idx + IW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running     <= 1'b0;
      idx         <= '0;
      mask_q      <= '0;
      start_pulse <= 1'b0;
      done        <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      done        <= 1'b0;
      if (launch && !running) begin
        running     <= 1'b1;
        mask_q      <= mask_in;
        idx         <= next_blk(mask_in, '0);
        start_pulse <= 1'b1;
      end else if (fail_hit) begin
        running <= 1'b0;
        done    <= 1'b1;
      end else if (pass_hit) begin
        if (nxt == IW'(N_BLK)) begin
          running <= 1'b0;
          done    <= 1'b1;
        end else begin
          idx <= nxt;
        end
      end
    end
  end

  assert_only_eligible_R4: assert property (@(posedge clk) disable iff (!rst_n)
    er_req |-> mask_q[er_blk]);
  assert_rising_order_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (er_req && $past(er_req && er_ack && !er_fail)) |-> (er_blk > $past(er_blk)));
  assert_stop_on_fail_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (er_req && er_ack && er_fail) |=> (!er_req && done));
  assert_suspend_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (er_req && !er_ack && suspend_req) |=> (er_req && $stable(er_blk)));
  assert_done_ends_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!running && $past(running)));
endmodule

// File: rtl/array_wipe_seq.sv
module array_wipe_seq
  import wipe_pkg::*;
#(
  parameter int               N_BLK     = 8,
  parameter logic [N_BLK-1:0] BOOT_MASK = N_BLK'(3),
  localparam int BW = (N_BLK > 1) ? $clog2(N_BLK) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [7:0]       cmd_data,
  input  logic             supply_ok,
  input  logic             wp_n,
  input  logic [N_BLK-1:0] lock_bits,
  input  logic             suspend_req,
  output logic             er_req,
  output logic [BW-1:0]    er_blk,
  input  logic             er_ack,
  input  logic             er_fail,
  output logic             ready_busy_n,
  output logic             start_pulse,
  output logic             done,
  output logic [7:0]       status
);
  logic             go, seq_err, running, fail_hit;
  logic [N_BLK-1:0] elig;
  logic             none_elig, sup_err, lock_err, launch;
  logic             e_erase, e_seq, e_sup, e_lock;

  wipe_cmd_gate u_gate (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .busy(running), .go(go), .seq_err(seq_err)
  );

  wipe_eligibility #(.N_BLK(N_BLK), .BOOT_MASK(BOOT_MASK)) u_elig (
    .lock_bits(lock_bits), .wp_n(wp_n), .elig(elig)
  );

  assign none_elig = (elig == '0);
  assign sup_err   = go && !supply_ok;
  assign lock_err  = go && supply_ok && none_elig;
  assign launch    = go && supply_ok && !none_elig;

  wipe_walker #(.N_BLK(N_BLK)) u_walk (
    .clk(clk), .rst_n(rst_n), .launch(launch), .mask_in(elig),
    .er_ack(er_ack), .er_fail(er_fail), .suspend_req(suspend_req),
    .running(running), .er_req(er_req), .er_blk(er_blk),
    .start_pulse(start_pulse), .done(done), .fail_hit(fail_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_erase <= 1'b0;
      e_seq   <= 1'b0;
      e_sup   <= 1'b0;
      e_lock  <= 1'b0;
    end else begin
      if (fail_hit || sup_err || lock_err || seq_err) e_erase <= 1'b1;
      if (seq_err)  e_seq  <= 1'b1;
      if (sup_err)  e_sup  <= 1'b1;
      if (lock_err) e_lock <= 1'b1;
    end
  end

  always_comb begin
    status            = '0;
    status[SB_READY]  = !running;
    status[SB_ERASE]  = e_erase;
    status[SB_SEQ]    = e_seq;
    status[SB_SUPPLY] = e_sup;
    status[SB_LOCK]   = e_lock;
  end
  assign ready_busy_n = !running;

  assert_low_supply_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !supply_ok) |=> (!er_req && status[SB_SUPPLY] && status[SB_ERASE]));
  assert_all_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (go && supply_ok && none_elig) |=> (!er_req && status[SB_LOCK] && status[SB_ERASE]));
  assert_bad_confirm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> (!start_pulse && ready_busy_n && status[SB_SEQ]));
  assert_sticky_errors_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $past(status[SB_ERASE]) |-> status[SB_ERASE]);
  assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> (!ready_busy_n && er_req));
endmodule

// File: tb/sim_array_wipe_seq.sv
module sim_array_wipe_seq;
  localparam int N = 8;
  localparam logic [N-1:0] BOOT = 8'h03;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_data = '0;
  logic supply_ok = 1'b1;
  logic wp_n = 1'b1;
  logic [N-1:0] lock_bits = '0;
  logic suspend_req = 1'b0;
  logic er_req, er_ack = 1'b0, er_fail = 1'b0;
  logic [2:0] er_blk;
  logic ready_busy_n, start_pulse, done;
  logic [7:0] status;

  int checks = 0, fails = 0, cyc = 0;
  int seq_log [0:15];
  int n_log = 0;
  int fail_blk = -1;
  int rsp_cnt = 0;

  array_wipe_seq #(.N_BLK(N), .BOOT_MASK(BOOT)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .supply_ok(supply_ok), .wp_n(wp_n), .lock_bits(lock_bits),
    .suspend_req(suspend_req), .er_req(er_req), .er_blk(er_blk),
    .er_ack(er_ack), .er_fail(er_fail), .ready_busy_n(ready_busy_n),
    .start_pulse(start_pulse), .done(done), .status(status)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // Array model: acknowledge two cycles after a request; suspend toggles
  always @(negedge clk) begin
    suspend_req = cyc[1];
    if (er_req && !er_ack) begin
      rsp_cnt++;
      if (rsp_cnt == 2) begin
        er_ack  = 1'b1;
        er_fail = (int'(er_blk) == fail_blk);
        if (n_log < 16) seq_log[n_log] = int'(er_blk);
        n_log++;
      end
    end else if (er_ack) begin
      er_ack  = 1'b0;
      er_fail = 1'b0;
      rsp_cnt = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_log = 0;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] v);
    cmd_valid = 1'b1;
    cmd_data  = v;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done();
    for (int t = 0; t < 400; t++) begin
      if (done) break;
      @(negedge clk);
    end
    check(done === 1'b1 && ready_busy_n === 1'b1, "R8 done with ready", {done, ready_busy_n}, 2'b11);
  endtask

  task automatic run_case(input logic [N-1:0] lk, input bit wp, input bit sup,
                          input int fb, input bit flip_lock, input bit mid_cmd);
    logic [N-1:0] el;
    int exp_list [0:15];
    int n_exp;
    bit hit;
    bit ok;
    logic [7:0] exp_st;
    do_reset();
    lock_bits = lk; wp_n = wp; supply_ok = sup; fail_blk = fb;
    n_exp = 0; hit = 0;
    for (int i = 0; i < N; i++)
      el[i] = !lk[i] && (!BOOT[i] || wp);
    for (int i = 0; i < N; i++)
      if (el[i] && !hit) begin
        exp_list[n_exp] = i; n_exp++;
        if (i == fb) hit = 1;
      end
    if (!sup)           begin exp_st = 8'hA8; n_exp = 0; end
    else if (el == '0)  exp_st = 8'hA2;
    else if (hit)       exp_st = 8'hA0;
    else                exp_st = 8'h80;
    send(8'h30);
    send(8'hD0);
    if (flip_lock) begin lock_bits = ~lk; wp_n = ~wp; end
    if (sup && el != '0) begin
      check(start_pulse === 1'b1 && ready_busy_n === 1'b0, "R1 R8 start and busy",
            {start_pulse, ready_busy_n}, 2'b10);
      if (mid_cmd) begin send(8'h30); send(8'hD0); end
      wait_done();
      @(negedge clk);
    end else begin
      check(start_pulse === 1'b0 && ready_busy_n === 1'b1, "R6 R7 no start",
            {start_pulse, ready_busy_n}, 2'b01);
      repeat (2) @(negedge clk);
    end
    check(status === exp_st, "R12 R5 R6 R7 status", status, exp_st);
    ok = (n_log == n_exp);
    for (int k = 0; k < n_exp && k < 16; k++)
      if (ok && seq_log[k] != exp_list[k]) ok = 0;
    check(ok, "R3 R4 R5 R10 erase list", n_log, n_exp);
    if (mid_cmd) begin
      // R11: a lone confirm after the run must not start anything
      send(8'hD0);
      check(start_pulse === 1'b0 && ready_busy_n === 1'b1, "R11 no rearm",
            {start_pulse, ready_busy_n}, 2'b01);
      repeat (3) @(negedge clk);
      check(n_log == n_exp && status === exp_st, "R11 log unchanged", n_log, n_exp);
    end
  endtask

  initial begin
    do_reset();
    check(status === 8'h80 && ready_busy_n === 1'b1 && er_req === 1'b0,
          "R12 reset state", status, 8'h80);

    // R2: bad second cycle, and a lone confirm
    do_reset();
    send(8'h30); send(8'h55);
    check(start_pulse === 1'b0 && ready_busy_n === 1'b1, "R2 no start", ready_busy_n, 1);
    @(negedge clk);
    check(status === 8'hB0 && n_log == 0, "R2 sequence error", status, 8'hB0);
    do_reset();
    send(8'h30); send(8'h30);
    @(negedge clk);
    check(status === 8'hB0 && n_log == 0, "R2 repeated setup", status, 8'hB0);
    do_reset();
    send(8'hD0);
    repeat (2) @(negedge clk);
    check(status === 8'h80 && n_log == 0, "R2 lone confirm", status, 8'h80);

    // R3 R4 R6 R9: every lock pattern with both write-protect levels
    for (int l = 0; l < 256; l++)
      for (int w = 0; w < 2; w++)
        run_case(l[N-1:0], w[0], 1'b1, -1, 1'b0, 1'b0);

    // R5: failure at each block position
    for (int f = 0; f < N; f++)
      run_case('0, 1'b1, 1'b1, f, 1'b0, 1'b0);
    run_case(8'h24, 1'b1, 1'b1, 5, 1'b0, 1'b0);   // failure on a locked block never occurs

    // R7: supply low
    run_case('0, 1'b1, 1'b0, -1, 1'b0, 1'b0);
    run_case(8'hFF, 1'b0, 1'b0, -1, 1'b0, 1'b0);

    // R10: locks and write-protect flipped right after confirm
    run_case(8'h5A, 1'b0, 1'b1, -1, 1'b1, 1'b0);
    run_case('0, 1'b1, 1'b1, -1, 1'b1, 1'b0);

    // R11: commands during a run
    run_case('0, 1'b1, 1'b1, -1, 1'b0, 1'b1);
    run_case(8'h0C, 1'b1, 1'b1, 6, 1'b0, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule